// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block handles the low-power state of a small processor core. When the instruction decoder executes a sleep command, it sends a one-cycle request. The controller then clears the power-down status flag and sets the timeout status flag. It sends a clear pulse to the watchdog counter, which keeps running, and it removes the oscillator enable. The core is held for as long as the controller is not in its running state.

While asleep, the controller checks three wake sources in a fixed priority order. An external reset request comes first. A watchdog timeout comes next, and it counts only while the watchdog is enabled. Last is any interrupt source whose flag and enable bit are both set. The global interrupt enable plays no part in waking.

A reset wake releases the core at once and pulses a core reset output. Watchdog and interrupt wakes continue the program. They first wait out an oscillator start-up delay of 2^OST_BITS cycles, which is skipped when the RC oscillator mode is selected. They then issue a one-cycle wake-done pulse. If the wake came from an interrupt and the global enable is set, a vector request comes with the pulse. The core then runs the instruction it has already fetched, followed by a dummy cycle and a branch to the interrupt vector. If an enabled interrupt is already pending when sleep is requested, the sleep still completes, but the controller wakes straight away and the oscillator never stops.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset: pd_flag=1, to_flag=1, osc_en=1, core_hold=0, wake_done=0, wake_cause=0 (encoding 0 none, 1 reset, 2 watchdog, 3 interrupt).
- R2: A sleep_req seen while running gives, one cycle later: pd_flag=0, to_flag=1, a single-cycle wdt_clr pulse, and core_hold=1. When no enabled interrupt is pending, osc_en=0 as well.
- R3: While asleep, ext_rst has priority over all other sources. One cycle later it gives core_rst=1, core_hold=0, osc_en=1, wake_cause=1 and no wake_done.
- R4: A watchdog wake needs wdt_en=1 and wdt_timeout=1, and it ranks above interrupts. It clears to_flag and sets wake_cause=2. With wdt_en=0 the timeout is ignored.
- R5: An interrupt wake needs irq_flag[i] and irq_en[i] set for the same index i, and it does not depend on gie. It sets wake_cause=3 and leaves to_flag at 1.
- R6: After a watchdog or interrupt wake, osc_en returns to 1 one cycle later. With osc_rc=0, wake_done pulses for one cycle exactly 2^OST_BITS cycles after that. With osc_rc=1 it pulses in the same cycle osc_en returns. core_hold falls in the cycle after wake_done.
- R7: vector_req is asserted only together with wake_done, and only when wake_cause=3 and gie=1.
- R8: If an enabled interrupt is pending when sleep_req arrives, the sleep completes (pd_flag=0, wdt_clr pulse), osc_en stays 1, and wake_done with wake_cause=3 follows one cycle later.
- R9: Every wake from sleep, whatever its source, gives a wdt_clr pulse in the cycle osc_en returns to 1.
- R10: Wake inputs have no effect while running. ext_rst and wdt_timeout there leave core_rst=0, to_flag unchanged and core_hold=0.
- R11: During the start-up delay, ext_rst and wdt_timeout are ignored. No core_rst pulse appears, the delay length does not change, and wake_cause is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req | input | 1 | One-cycle sleep command from the decoder |
| ext_rst | input | 1 | External reset request |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog timeout event |
| irq_flag | input | N_IRQ | Per-source interrupt flags |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| osc_rc | input | 1 | 1 selects RC oscillator mode (no start-up delay) |
| osc_en | output | 1 | Oscillator driver enable |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Timeout status flag |
| wdt_clr | output | 1 | Watchdog clear pulse |
| core_hold | output | 1 | Stall the core |
| core_rst | output | 1 | Core reset pulse after a reset wake |
| wake_done | output | 1 | Resume pulse after a continuing wake |
| vector_req | output | 1 | Branch to interrupt vector after the prefetched instruction |
| wake_cause | output | 2 | Cause of the last wake |

## Verification
The bench covers every combination of wake source, gie and oscillator mode, with each interrupt index used in turn. This separates the in-line resume from the vectored resume, and the full start-up delay from the skipped one. Before each wake it applies decoys that must not wake the core: a timeout with the watchdog disabled, and flags whose enables sit on other indices. The wake itself stacks lower-priority sources on top of the winning one, so that the priority order and the per-index matching are tested. Further cases cover wake inputs seen while running, reset and timeout pulses during the start-up delay, and a sleep request made with an interrupt already pending.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_IRQ    = 3,
  parameter int OST_BITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             ext_rst,
  input  logic             wdt_en,
  input  logic             wdt_timeout,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             osc_rc,
  output logic             osc_en,
  output logic             pd_flag,
  output logic             to_flag,
  output logic             wdt_clr,
  output logic             core_hold,
  output logic             core_rst,
  output logic             wake_done,
  output logic             vector_req,
  output logic [1:0]       wake_cause
);

  localparam logic [OST_BITS-1:0] OST_LAST = '1;
  localparam logic [1:0] C_NONE = 2'd0, C_RST = 2'd1, C_WDT = 2'd2, C_IRQ = 2'd3;

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_OST, S_DONE} st_t;

  st_t                st;
  logic [OST_BITS-1:0] ost_cnt;

  wire irq_pend = |(irq_flag & irq_en);
  wire wdt_wake = wdt_en & wdt_timeout;
  wire st_t_unused = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      ost_cnt    <= '0;
      pd_flag    <= 1'b1;
      to_flag    <= 1'b1;
      wdt_clr    <= 1'b0;
      core_rst   <= 1'b0;
      wake_cause <= C_NONE;
    end else begin
      wdt_clr  <= 1'b0;
      core_rst <= 1'b0;
      case (st)
        S_RUN: if (sleep_req) begin
          pd_flag <= 1'b0;
          to_flag <= 1'b1;
          wdt_clr <= 1'b1;
          if (irq_pend) begin
            wake_cause <= C_IRQ;
            st         <= S_DONE;
          end else begin
            wake_cause <= C_NONE;
            st         <= S_SLEEP;
          end
        end
        S_SLEEP: begin
          ost_cnt <= '0;
          if (ext_rst) begin
            core_rst   <= 1'b1;
            wdt_clr    <= 1'b1;
            wake_cause <= C_RST;
            st         <= S_RUN;
          end else if (wdt_wake) begin
            to_flag    <= 1'b0;
            wdt_clr    <= 1'b1;
            wake_cause <= C_WDT;
            st         <= osc_rc ? S_DONE : S_OST;
          end else if (irq_pend) begin
            wdt_clr    <= 1'b1;
            wake_cause <= C_IRQ;
            st         <= osc_rc ? S_DONE : S_OST;
          end
        end
        S_OST: begin
          ost_cnt <= ost_cnt + 1'b1;
          if (ost_cnt == OST_LAST) st <= S_DONE;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign osc_en     = (st != S_SLEEP) | st_t_unused;
  assign core_hold  = (st != S_RUN);
  assign wake_done  = (st == S_DONE);
  assign vector_req = wake_done & gie & (wake_cause == C_IRQ);

endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       gie,
  input logic       osc_en,
  input logic       pd_flag,
  input logic       to_flag,
  input logic       wdt_clr,
  input logic       core_hold,
  input logic       core_rst,
  input logic       wake_done,
  input logic       vector_req,
  input logic [1:0] wake_cause
);

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !core_hold) |=> (!pd_flag && to_flag && wdt_clr && core_hold));

  assert_pd_never_rises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pd_flag));

  assert_rst_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (!core_hold && osc_en && wake_cause == 2'd1 && !wake_done));

  assert_to_clear_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_flag) |-> (wake_cause == 2'd2));

  assert_osc_off_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> core_hold);

  assert_vector_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vector_req |-> (wake_done && gie && wake_cause == 2'd3));

  assert_wake_clears_wdt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> wdt_clr);

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .gie(gie),
  .osc_en(osc_en), .pd_flag(pd_flag), .to_flag(to_flag), .wdt_clr(wdt_clr),
  .core_hold(core_hold), .core_rst(core_rst), .wake_done(wake_done),
  .vector_req(vector_req), .wake_cause(wake_cause)
);

// File: tb/sleep_wake_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_bench;
  localparam int N_IRQ = 3;
  localparam int OST_BITS = 10;
  localparam int OST_LEN = 1 << OST_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, ext_rst = 1'b0, wdt_en = 1'b0, wdt_timeout = 1'b0;
  logic [N_IRQ-1:0] irq_flag = '0, irq_en = '0;
  logic gie = 1'b0, osc_rc = 1'b0;
  logic osc_en, pd_flag, to_flag, wdt_clr, core_hold, core_rst, wake_done, vector_req;
  logic [1:0] wake_cause;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(N_IRQ), .OST_BITS(OST_BITS)) u_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ext_rst(ext_rst),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .irq_flag(irq_flag),
    .irq_en(irq_en), .gie(gie), .osc_rc(osc_rc), .osc_en(osc_en),
    .pd_flag(pd_flag), .to_flag(to_flag), .wdt_clr(wdt_clr),
    .core_hold(core_hold), .core_rst(core_rst), .wake_done(wake_done),
    .vector_req(vector_req), .wake_cause(wake_cause)
  );

  task automatic eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    ext_rst = 1'b0; wdt_timeout = 1'b0; irq_flag = '0; irq_en = '0; wdt_en = 1'b1;
  endtask

  task automatic enter_sleep();
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
    eq("R2", "pd_flag", pd_flag, 0);
    eq("R2", "to_flag", to_flag, 1);
    eq("R2", "wdt_clr", wdt_clr, 1);
    eq("R2", "osc_en", osc_en, 0);
    eq("R2", "core_hold", core_hold, 1);
    @(negedge clk);
    eq("R2", "wdt_clr pulse end", wdt_clr, 0);
    eq("R2", "osc_en still off", osc_en, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    eq("R1", "pd_flag", pd_flag, 1);
    eq("R1", "to_flag", to_flag, 1);
    eq("R1", "osc_en", osc_en, 1);
    eq("R1", "core_hold", core_hold, 0);
    eq("R1", "wake_done", wake_done, 0);
    eq("R1", "wake_cause", wake_cause, 0);

    @(negedge clk) begin wdt_en = 1'b1; wdt_timeout = 1'b1; ext_rst = 1'b1; end
    @(negedge clk) clear_in();
    eq("R10", "core_rst", core_rst, 0);
    eq("R10", "to_flag", to_flag, 1);
    eq("R10", "core_hold", core_hold, 0);
    eq("R10", "wdt_clr", wdt_clr, 0);

    for (int src = 0; src < 5; src++) begin
      for (int g = 0; g < 2; g++) begin
        for (int rc = 0; rc < 2; rc++) begin
          int idx;
          int cyc;
          bit saw_rst;
          idx = (src >= 2) ? src - 2 : (g + rc) % N_IRQ;
          gie = g[0]; osc_rc = rc[0]; clear_in();
          enter_sleep();

          @(negedge clk) begin
            wdt_en = 1'b0; wdt_timeout = 1'b1;
            irq_flag = N_IRQ'(1) << idx; irq_en = ~(N_IRQ'(1) << idx);
          end
          @(negedge clk) clear_in();
          eq("R4", "disabled timeout: osc_en", osc_en, 0);
          eq("R5", "mismatched enables: core_hold", core_hold, 1);
          eq("R5", "no wake: wdt_clr", wdt_clr, 0);

          @(negedge clk) begin
            if (src == 0) begin
              ext_rst = 1'b1; wdt_timeout = 1'b1; irq_flag = '1; irq_en = '1;
            end else if (src == 1) begin
              wdt_timeout = 1'b1; irq_flag = '1; irq_en = '1;
            end else begin
              irq_flag = N_IRQ'(1) << idx; irq_en = N_IRQ'(1) << idx;
            end
          end
          @(negedge clk) clear_in();
          eq("R9", "wdt_clr on wake", wdt_clr, 1);
          eq("R6", "osc_en back", osc_en, 1);
          if (src == 0) begin
            eq("R3", "wake_cause", wake_cause, 1);
            eq("R3", "core_rst", core_rst, 1);
            eq("R3", "core_hold", core_hold, 0);
            eq("R3", "wake_done", wake_done, 0);
            eq("R3", "to_flag", to_flag, 1);
          end else begin
            eq(src == 1 ? "R4" : "R5", "wake_cause", wake_cause, src == 1 ? 2 : 3);
            eq(src == 1 ? "R4" : "R5", "to_flag", to_flag, src == 1 ? 0 : 1);
            cyc = 0; saw_rst = 1'b0;
            while (!wake_done && cyc < 3000) begin
              @(negedge clk);
              if (core_rst) saw_rst = 1'b1;
              cyc++;
              ext_rst = (cyc == 5);
              wdt_timeout = (cyc == 6);
            end
            ext_rst = 1'b0; wdt_timeout = 1'b0;
            eq("R6", "start-up cycles", cyc, rc ? 0 : OST_LEN);
            eq("R11", "core_rst during delay", saw_rst, 0);
            eq("R11", "wake_cause kept", wake_cause, src == 1 ? 2 : 3);
            eq("R7", "vector_req", vector_req, (src >= 2 && g == 1) ? 1 : 0);
            @(negedge clk);
            eq("R6", "core_hold released", core_hold, 0);
            eq("R6", "wake_done one cycle", wake_done, 0);
            eq("R7", "vector_req off", vector_req, 0);
          end
        end
      end
    end

    gie = 1'b1; osc_rc = 1'b0;
    @(negedge clk) begin irq_flag = 3'b010; irq_en = 3'b010; sleep_req = 1'b1; end
    @(negedge clk) begin sleep_req = 1'b0; clear_in(); end
    eq("R8", "osc_en stays", osc_en, 1);
    eq("R8", "pd_flag", pd_flag, 0);
    eq("R8", "wdt_clr", wdt_clr, 1);
    eq("R8", "wake_done", wake_done, 1);
    eq("R8", "wake_cause", wake_cause, 3);
    eq("R7", "vector_req on pending", vector_req, 1);
    @(negedge clk);
    eq("R8", "core_hold released", core_hold, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule